// File: doc/BRIEF.md
# 68000 Bus to RCBus Bridge Glue

This block sits between a 68000-style asynchronous processor bus and a Z80-style backplane. It classifies each processor bus cycle by the upper address bits and the function code. A cycle can land in a backplane memory window, a backplane I/O window, an interrupt-acknowledge cycle, or elsewhere. For window cycles it drives active-low memory-request or I/O-request strobes together with active-low read or write strobes. It passes the low address bits straight through, and it returns a data-transfer acknowledge after a fixed number of wait cycles.

Cycles outside the windows are left to the addressed device, which returns its own acknowledge on a separate input. If no acknowledge of any kind arrives, a watchdog raises bus error. Interrupt-acknowledge cycles are answered with an autovector request and nothing else.

The processor strobes and the external acknowledge pass through two-stage synchronizers before they drive the counters. The address strobe itself also gates every output directly, so all outputs drop the moment the processor ends its cycle. Reset is synchronous and active high.

Top module: `mbus_bridge`

## Requirements
- R1: While the address strobe is low and cpu_addr[23:19] equals 5'b11110 (addresses 0xF00000 to 0xF7FFFF) in a non-interrupt cycle, mreq_n goes low and iorq_n stays high.
- R2: While the address strobe is low and cpu_addr[23:19] equals 5'b11111 (addresses 0xF80000 to 0xFFFFFF) in a non-interrupt cycle, iorq_n goes low and mreq_n stays high.
- R3: During a window cycle, bp_addr equals cpu_addr[18:0] unchanged.
- R4: The first rising clock edge that samples as_n low counts as edge 1. The backplane strobes appear after edge 2, and dtack_n goes low after edge WAIT_CYC+2 (default 4). dtack_n stays high for every cycle outside both windows.
- R5: In a window cycle, rd_n is low when rw is 1. wr_n is low when rw is 0 and uds_n or lds_n is low. rd_n and wr_n are never low together.
- R6: When as_n is high, mreq_n, iorq_n, rd_n, wr_n, dtack_n, berr_n and vpa_n are all high in that same cycle, with no clock needed.
- R7: A cycle that gets no acknowledge (no dtack, no autovector, no dev_ack_n) drives berr_n low after edge TIMEOUT+2 (default 66). berr_n then stays low until as_n rises.
- R8: If dev_ack_n goes low before the timeout expires, berr_n stays high for the rest of that cycle, however long the cycle lasts.
- R9: When fc equals 3'b111 with the address strobe low, vpa_n goes low after edge 2. In that cycle mreq_n, iorq_n, rd_n, wr_n and dtack_n stay high, even when the address falls in the I/O window.
- R10: While rst is high, every active-low output stays high, even when as_n is low with a window address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 24 | Processor address |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Processor function code |
| dev_ack_n | input | 1 | Acknowledge from a device outside the windows, active low |
| bp_addr | output | 19 | Address bits passed to the backplane |
| mreq_n | output | 1 | Backplane memory request |
| iorq_n | output | 1 | Backplane I/O request |
| rd_n | output | 1 | Backplane read strobe |
| wr_n | output | 1 | Backplane write strobe |
| dtack_n | output | 1 | Data-transfer acknowledge to the processor |
| berr_n | output | 1 | Bus error to the processor |
| vpa_n | output | 1 | Autovector request to the processor |

## Verification
Reads and writes are driven at both edges of each window (0xF00000, 0xF7FFFE, 0xF80000, 0xFFFFFE), and under more than one function code. These cycles separate the memory strobe from the I/O strobe and the read strobe from the write strobe, and they confirm the exact edge on which the acknowledge appears. Cycles just below the memory window and far from both windows are run twice: once with a late device acknowledge, which must suppress bus error, and once with none, which must raise bus error on the timeout edge and hold it. An interrupt-acknowledge cycle placed at an I/O-window address shows that the autovector path takes priority over the window decode. A reset held while the strobe sits low on a window address shows that reset gates every output.

// File: rtl/mbus_bridge_pkg.sv
package mbus_bridge_pkg;

    // Cycle classes produced by the address/function-code decoder
    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_MEM  = 2'd1,
        CYC_IO   = 2'd2,
        CYC_IACK = 2'd3
    } cyc_kind_e;

    // Function code of an interrupt-acknowledge cycle
    localparam logic [2:0] FC_INT_ACK = 3'b111;

    // Internal active-high view of the bridge outputs
    typedef struct packed {
        logic mreq;
        logic iorq;
        logic rd;
        logic wr;
        logic dtack;
        logic berr;
        logic vpa;
    } bridge_resp_t;

    // Synchronized processor-side inputs (active high)
    typedef struct packed {
        logic strobe;
        logic data;
        logic ack;
    } cpu_sync_t;

    function automatic logic owns_cycle(cyc_kind_e k);
        return (k == CYC_MEM) || (k == CYC_IO);
    endfunction

endpackage

// File: rtl/mbb_sync.sv
module mbb_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic stage1, stage2;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= d[i];
                stage2 <= stage1;
            end
        end
        assign q[i] = stage2;
    end
endmodule

// File: rtl/mbb_decode.sv
module mbb_decode
    import mbus_bridge_pkg::*;
#(
    parameter int                TAG_W   = 5,
    parameter logic [TAG_W-1:0]  MEM_TAG = 5'b11110,
    parameter logic [TAG_W-1:0]  IO_TAG  = 5'b11111
) (
    input  logic [TAG_W-1:0] tag,
    input  logic [2:0]       fc,
    output cyc_kind_e        kind
);
    always_comb begin
        if (fc == FC_INT_ACK)      kind = CYC_IACK;
        else if (tag == MEM_TAG)   kind = CYC_MEM;
        else if (tag == IO_TAG)    kind = CYC_IO;
        else                       kind = CYC_NONE;
    end
endmodule

// File: rtl/mbb_timer.sv
module mbb_timer #(
    parameter int WAIT_CYC = 2,
    parameter int TIMEOUT  = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic active,   // synchronized strobe
    input  logic own,      // bridge answers this cycle itself
    input  logic ack,      // some other acknowledge present now
    output logic dtack_due,
    output logic berr_due
);
    localparam int MAXV = (WAIT_CYC > TIMEOUT) ? WAIT_CYC : TIMEOUT;
    localparam int CW   = $clog2(MAXV + 1);
    localparam logic [CW-1:0] WAIT_V = CW'(WAIT_CYC);
    localparam logic [CW-1:0] TOUT_V = CW'(TIMEOUT);
    localparam logic [CW-1:0] MAX_V  = CW'(MAXV);

    logic [CW-1:0] count;
    logic          acked;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            count <= '0;
            acked <= 1'b0;
        end else begin
            if (count != MAX_V) count <= count + 1'b1;
            if (ack)            acked <= 1'b1;
        end
    end

    assign dtack_due = (count >= WAIT_V);
    assign berr_due  = !own && !acked && !ack && (count >= TOUT_V);
endmodule

// File: rtl/mbus_bridge.sv
module mbus_bridge
    import mbus_bridge_pkg::*;
#(
    parameter int                          ADDR_W   = 24,
    parameter int                          PASS_W   = 19,
    parameter logic [ADDR_W-PASS_W-1:0]    MEM_TAG  = 5'b11110,
    parameter logic [ADDR_W-PASS_W-1:0]    IO_TAG   = 5'b11111,
    parameter int                          WAIT_CYC = 2,
    parameter int                          TIMEOUT  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rw,
    input  logic [2:0]        fc,
    input  logic              dev_ack_n,
    output logic [PASS_W-1:0] bp_addr,
    output logic              mreq_n,
    output logic              iorq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              dtack_n,
    output logic              berr_n,
    output logic              vpa_n
);
    localparam int TAG_W = ADDR_W - PASS_W;

    cpu_sync_t    raw_in, sync_in;
    cyc_kind_e    kind;
    bridge_resp_t resp;
    logic         live, own, any_ds, dtack_due, berr_due;

    assign any_ds = !(uds_n && lds_n);
    assign raw_in = '{strobe: !as_n, data: any_ds, ack: !dev_ack_n};

    mbb_sync #(.WIDTH($bits(cpu_sync_t))) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    mbb_decode #(.TAG_W(TAG_W), .MEM_TAG(MEM_TAG), .IO_TAG(IO_TAG)) u_decode (
        .tag  (cpu_addr[ADDR_W-1:PASS_W]),
        .fc   (fc),
        .kind (kind)
    );

    assign own = owns_cycle(kind);

    mbb_timer #(.WAIT_CYC(WAIT_CYC), .TIMEOUT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .active    (sync_in.strobe),
        .own       (own),
        .ack       (sync_in.ack || (kind == CYC_IACK)),
        .dtack_due (dtack_due),
        .berr_due  (berr_due)
    );

    // The raw strobe gates everything so release needs no clock edge
    assign live = !rst && !as_n && sync_in.strobe;

    always_comb begin
        resp       = '0;
        resp.mreq  = live && (kind == CYC_MEM);
        resp.iorq  = live && (kind == CYC_IO);
        resp.rd    = live && own && rw;
        resp.wr    = live && own && !rw && sync_in.data && any_ds;
        resp.dtack = live && own && dtack_due;
        resp.berr  = live && berr_due;
        resp.vpa   = live && (kind == CYC_IACK);
    end

    assign bp_addr = cpu_addr[PASS_W-1:0];
    assign mreq_n  = !resp.mreq;
    assign iorq_n  = !resp.iorq;
    assign rd_n    = !resp.rd;
    assign wr_n    = !resp.wr;
    assign dtack_n = !resp.dtack;
    assign berr_n  = !resp.berr;
    assign vpa_n   = !resp.vpa;
endmodule

// File: rtl/mbb_checker.sv
module mbb_checker #(
    parameter int                       ADDR_W  = 24,
    parameter int                       PASS_W  = 19,
    parameter logic [ADDR_W-PASS_W-1:0] MEM_TAG = 5'b11110,
    parameter logic [ADDR_W-PASS_W-1:0] IO_TAG  = 5'b11111
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              as_n,
    input logic [2:0]        fc,
    input logic              mreq_n,
    input logic              iorq_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              dtack_n,
    input logic              berr_n,
    input logic              vpa_n
);
    // R1: memory strobe only inside the memory window, outside interrupt cycles
    a_r1_mreq_window: assert property (@(posedge clk) disable iff (rst)
        !mreq_n |-> (!as_n && cpu_addr[ADDR_W-1:PASS_W] == MEM_TAG && fc != 3'b111));

    // R2: I/O strobe only inside the I/O window
    a_r2_iorq_window: assert property (@(posedge clk) disable iff (rst)
        !iorq_n |-> (!as_n && cpu_addr[ADDR_W-1:PASS_W] == IO_TAG && fc != 3'b111));

    // R4: acknowledge only while the bridge drives a backplane cycle
    a_r4_dtack_owned: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> (!mreq_n || !iorq_n));

    // R5: read and write strobes mutually exclusive
    a_r5_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R6: nothing active once the address strobe is high
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        as_n |-> (mreq_n && iorq_n && rd_n && wr_n && dtack_n && berr_n && vpa_n));

    // R7: bus error holds until the strobe rises, never alongside an acknowledge
    a_r7_berr_hold: assert property (@(posedge clk) disable iff (rst)
        (!berr_n && !as_n) |=> (!berr_n || as_n));
    a_r7_berr_no_dtack: assert property (@(posedge clk) disable iff (rst)
        !berr_n |-> dtack_n);

    // R9: autovector cycle touches neither backplane nor acknowledge
    a_r9_iack_quiet: assert property (@(posedge clk) disable iff (rst)
        !vpa_n |-> (mreq_n && iorq_n && rd_n && wr_n && dtack_n));

    // R10: reset gates every output
    always @(posedge clk) begin
        if (rst) begin
            a_r10_reset_quiet: assert (mreq_n && iorq_n && rd_n && wr_n
                                       && dtack_n && berr_n && vpa_n);
        end
    end
endmodule

bind mbus_bridge mbb_checker #(
    .ADDR_W (ADDR_W),
    .PASS_W (PASS_W),
    .MEM_TAG(MEM_TAG),
    .IO_TAG (IO_TAG)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cpu_addr(cpu_addr),
    .as_n    (as_n),
    .fc      (fc),
    .mreq_n  (mreq_n),
    .iorq_n  (iorq_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .dtack_n (dtack_n),
    .berr_n  (berr_n),
    .vpa_n   (vpa_n)
);

// File: tb/sim_mbus_bridge.sv
`timescale 1ns/1ps
module sim_mbus_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] cpu_addr = '0;
    logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
    logic [2:0]  fc = 3'b101;
    logic        dev_ack_n = 1'b1;
    logic [18:0] bp_addr;
    logic        mreq_n, iorq_n, rd_n, wr_n, dtack_n, berr_n, vpa_n;

    always #4 clk = ~clk;  // 125 MHz

    mbus_bridge u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .as_n(as_n), .uds_n(uds_n),
        .lds_n(lds_n), .rw(rw), .fc(fc), .dev_ack_n(dev_ack_n), .bp_addr(bp_addr),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .dtack_n(dtack_n), .berr_n(berr_n), .vpa_n(vpa_n)
    );

    typedef struct {
        bit          mreq, iorq, rd, wr, berr_last;
        int          dtack_at, berr_at, vpa_at;
        logic [18:0] addr;
        string       name;
    } item_t;

    item_t exp_q[$];
    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver: pushes the expectation, then runs one processor bus cycle
    task automatic bus_cycle(input logic [23:0] a, input bit rd_cyc, input logic [2:0] f,
                             input int ack_at, input int limit, input int hold,
                             input item_t e);
        int n = 0;
        exp_q.push_back(e);
        @(negedge clk);
        cpu_addr = a; rw = rd_cyc; fc = f; as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        while (1) begin
            @(posedge clk); #2;
            n++;
            if (ack_at != 0 && n == ack_at) dev_ack_n = 1'b0;
            if (!dtack_n || !berr_n || !vpa_n || n >= limit) break;
        end
        repeat (hold) @(posedge clk);
        @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; dev_ack_n = 1'b1;
        #1;
        check(mreq_n && iorq_n && rd_n && wr_n && dtack_n && berr_n && vpa_n,
              "R6", {e.name, " release"},
              {mreq_n, iorq_n, rd_n, wr_n, dtack_n, berr_n, vpa_n}, 7'h7f);
        repeat (3) @(posedge clk);
    endtask

    // Monitor: observes each cycle at the ports and compares with the queue
    initial begin
        bit in_cyc = 1'b0, m = 1'b0, io = 1'b0, r = 1'b0, w = 1'b0, bl = 1'b0, cap = 1'b0;
        int idx = 0, d_at = 0, b_at = 0, v_at = 0;
        logic [18:0] a = '0;
        item_t e;
        while (!done) begin
            @(posedge clk); #2;
            if (rst) continue;
            if (!as_n) begin
                if (!in_cyc) begin
                    in_cyc = 1'b1; idx = 0; m = 0; io = 0; r = 0; w = 0; bl = 0;
                    cap = 0; d_at = 0; b_at = 0; v_at = 0; a = '0;
                end
                idx++;
                if (!mreq_n) m = 1'b1;
                if (!iorq_n) io = 1'b1;
                if (!rd_n) r = 1'b1;
                if (!wr_n) w = 1'b1;
                if (!dtack_n && d_at == 0) d_at = idx;
                if (!berr_n && b_at == 0) b_at = idx;
                if (!vpa_n && v_at == 0) v_at = idx;
                if ((!mreq_n || !iorq_n) && !cap) begin cap = 1'b1; a = bp_addr; end
                bl = !berr_n;
            end else if (in_cyc) begin
                in_cyc = 1'b0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected cycle", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(m == e.mreq, "R1", {e.name, " mreq"}, m, e.mreq);
                    check(io == e.iorq, "R2", {e.name, " iorq"}, io, e.iorq);
                    check(a == e.addr, "R3", {e.name, " addr"}, a, e.addr);
                    check(d_at == e.dtack_at, "R4", {e.name, " dtack edge"}, d_at, e.dtack_at);
                    check(r == e.rd && w == e.wr, "R5", {e.name, " rd/wr"},
                          {r, w}, {e.rd, e.wr});
                    check(b_at == e.berr_at && bl == e.berr_last, "R7",
                          {e.name, " berr edge"}, b_at, e.berr_at);
                    check(v_at == e.vpa_at, "R9", {e.name, " vpa edge"}, v_at, e.vpa_at);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R4", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic item_t mk(input string nm, input bit m, input bit io, input bit r,
                                 input bit w, input int d, input int b, input int v,
                                 input logic [18:0] a);
        item_t e;
        e.name = nm; e.mreq = m; e.iorq = io; e.rd = r; e.wr = w;
        e.dtack_at = d; e.berr_at = b; e.vpa_at = v; e.addr = a; e.berr_last = (b != 0);
        return e;
    endfunction

    initial begin
        // R10: reset held while a window cycle is presented
        cpu_addr = 24'hF00000; as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        repeat (5) @(posedge clk);
        #2;
        check(mreq_n && iorq_n && rd_n && wr_n && dtack_n && berr_n && vpa_n, "R10",
              "outputs during reset", {mreq_n, iorq_n, rd_n, wr_n, dtack_n, berr_n, vpa_n},
              7'h7f);
        @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (3) @(posedge clk);

        // R1/R3/R4/R5: memory window, both ends
        bus_cycle(24'hF00000, 1, 3'b101, 0, 100, 0, mk("mem rd low", 1, 0, 1, 0, 4, 0, 0, 19'h00000));
        bus_cycle(24'hF7FFFE, 0, 3'b101, 0, 100, 2, mk("mem wr high", 1, 0, 0, 1, 4, 0, 0, 19'h7FFFE));
        bus_cycle(24'hF12345, 1, 3'b010, 0, 100, 1, mk("mem rd user", 1, 0, 1, 0, 4, 0, 0, 19'h12345));
        // R2: I/O window, both ends
        bus_cycle(24'hF80000, 1, 3'b101, 0, 100, 0, mk("io rd low", 0, 1, 1, 0, 4, 0, 0, 19'h00000));
        bus_cycle(24'hFFFFFE, 0, 3'b101, 0, 100, 0, mk("io wr high", 0, 1, 0, 1, 4, 0, 0, 19'h7FFFE));
        // R8: device outside windows acknowledges itself, no bus error
        bus_cycle(24'hEFFFFE, 1, 3'b101, 10, 80, 0, mk("ext ack", 0, 0, 0, 0, 0, 0, 0, 19'h0));
        // R7: unacknowledged cycles time out and hold bus error
        bus_cycle(24'h100000, 1, 3'b101, 0, 100, 3, mk("timeout rd", 0, 0, 0, 0, 0, 66, 0, 19'h0));
        bus_cycle(24'hEFFFFE, 0, 3'b101, 0, 100, 0, mk("timeout wr", 0, 0, 0, 0, 0, 66, 0, 19'h0));
        // R9: interrupt acknowledge at an I/O-window address
        bus_cycle(24'hFFFFF6, 1, 3'b111, 0, 100, 2, mk("iack", 0, 0, 0, 0, 0, 0, 2, 19'h0));
        // Back-to-back window cycle after the others
        bus_cycle(24'hF80042, 0, 3'b001, 0, 100, 0, mk("io wr user", 0, 1, 0, 1, 4, 0, 0, 19'h00042));

        repeat (5) @(posedge clk);
        check(exp_q.size() == 0, "R4", "pending expectations", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule